// File: doc/BRIEF.md
# String Operation Execution Sequencer

This block carries out a single pass of a string-style data transfer or comparison for a processor core. A caller hands it a latched operation: the kind (move, compare, store, load, scan, port input, port output), an element width of one, two or four bytes, and an address-width select. Along with these come the direction bit, the accumulator, both index registers, the port number, the two segment bases and three segment access-right bits. The block then walks through that operation's memory and I/O accesses one at a time over a shared request channel. It finishes with a one-cycle `done` and reports the updated index registers, accumulator, subtract flags and a fixed cycle cost.

Before it touches the channel, the block checks the segment rights the operation needs. Any refused access ends the pass with a one-cycle `abort` and a fault code. An abort leaves the architectural results as they were, with one exception. Port output advances the source index before it issues the port write. A fault on that final write therefore leaves the source index already stepped. Repetition, descriptor loading, paging and decode belong to the surrounding core.

Top module: `strop_seq`

## Requirements
- R1: After `done`, every index the operation uses has moved by the element size (1, 2 or 4): down when `dir_in` was 1, up when it was 0. The move and compare kinds step both indices. Load and port output step only the source index. Store, scan and port input step only the destination index. An index the operation does not use comes back unchanged.
- R2: With `addr32_in` = 0, addresses use only bits [15:0] of an index, zero-extended. Only those bits step, wrapping modulo 2^16, and bits [31:16] come back unchanged. With `addr32_in` = 1, the full 32-bit index is used and steps modulo 2^32.
- R3: Move issues a memory read (kind 0) at `src_base_in` + source index, then a memory write (kind 1) at `dst_base_in` + destination index. The write data equals the read data masked to the element width.
- R4: Compare reads the source, then the destination, and sets the flags from source minus destination. Scan reads only the destination and sets the flags from the accumulator minus that operand. Operands are masked to the element width. Flag bits are {overflow[5], sign[4], zero[3], aux-carry[2], parity[1], carry[0]}. Parity is 1 when the low byte of the result has an even number of ones. No other kind changes `flags_out`.
- R5: Store writes the accumulator, masked to the width, at the destination. Load reads the source and replaces only the low 8, 16 or 32 bits of `acc_out`. The upper accumulator bits keep their value.
- R6: Port input issues one permission probe (kind 4) for each byte the access covers, at port, port+1, and so on up to the element width. It then issues one port read (kind 2) at the port number. Last, it writes the masked port data to the destination.
- R7: Port output reads the source, then probes each covered port byte, then issues the port write (kind 3) with the masked read data. The source index is committed before that write, so an access fault on the port write still returns the stepped source index.
- R8: On `done`, `cycles_out` is 7 for move, 10 for compare (8 when `cmp486_in` = 1), 4 for store, 5 for load, 7 for scan, 15 for port input and 14 for port output. On `abort` it is 0.
- R9: At `start` the block checks segment rights. A source read is needed for move, compare, load and port output. A destination write is needed for move, store and port input. A destination read is needed for compare and scan. A refused source gives code 1, checked first. A refused destination gives code 2. Either one aborts on the next cycle with no request issued.
- R10: A `rsp_fault` ends the pass with a single-cycle `abort`. The code is 4 if the faulting request was a permission probe and 3 otherwise. Index and accumulator outputs return to their start values (except R7's case), `flags_out` holds, and `busy` is low. `done` and `abort` never assert together.
- R11: `busy` is high from the cycle after an accepted `start` until the pass ends. One request is presented at a time, held stable with `req_valid` high until `rsp_ready` or `rsp_fault`. `done` lasts one cycle. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a pass (accepted while idle) |
| op_in | input | 3 | Kind: 0 move, 1 compare, 2 store, 3 load, 4 scan, 5 port in, 6 port out |
| size_in | input | 2 | Element width: 0 byte, 1 word, 2 doubleword |
| addr32_in | input | 1 | 1 selects 32-bit indices, 0 selects 16-bit |
| dir_in | input | 1 | 1 steps indices down, 0 up |
| cmp486_in | input | 1 | Selects the shorter compare cost |
| acc_in | input | 32 | Accumulator |
| src_idx_in | input | IDX_W | Source index |
| dst_idx_in | input | IDX_W | Destination index |
| port_in | input | PORT_W | Port number |
| src_base_in | input | 32 | Source segment base |
| dst_base_in | input | 32 | Destination segment base |
| src_rd_ok | input | 1 | Source segment readable |
| dst_rd_ok | input | 1 | Destination segment readable |
| dst_wr_ok | input | 1 | Destination segment writable |
| req_valid | output | 1 | Request present |
| req_kind | output | 3 | 0 mem read, 1 mem write, 2 port read, 3 port write, 4 permission probe |
| req_addr | output | 32 | Linear address or port number |
| req_size | output | 2 | Element width code |
| req_wdata | output | 32 | Write data (masked) |
| rsp_ready | input | 1 | Request completed |
| rsp_fault | input | 1 | Request refused |
| rsp_rdata | input | 32 | Read data |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle completion pulse |
| abort | output | 1 | One-cycle fault pulse |
| fault_code | output | 3 | 0 none, 1 source segment, 2 destination segment, 3 access, 4 port permission |
| src_idx_out | output | IDX_W | Resulting source index |
| dst_idx_out | output | IDX_W | Resulting destination index |
| acc_out | output | 32 | Resulting accumulator |
| flags_out | output | 6 | Subtract flags as in R4 |
| cycles_out | output | CYC_W | Reported cycle cost |

## Verification
The bench drives every kind at every width, in both address modes and both directions, with start indices next to the 16-bit wrap points. An adder that carries into bit 16, or a mode that ignores the direction, shows up as a wrong index or address. It injects a fault at each position of each access sequence. This catches an index that moves on abort, the wrong fault code on a permission probe, and a port-output pass that rolls its source index back when only the port write fails. Read data arrives with junk in the unused upper bytes and wait states between responses. A design that forgets to mask would write or compare stale bytes, and one that drops a held request would skip or repeat an access.

// File: rtl/strop_pkg.sv
package strop_pkg;

    localparam int XW     = 32;
    localparam int NARROW = 16;

    typedef enum logic [2:0] {
        OP_MOVE  = 3'd0,
        OP_CMP   = 3'd1,
        OP_STORE = 3'd2,
        OP_LOAD  = 3'd3,
        OP_SCAN  = 3'd4,
        OP_IN    = 3'd5,
        OP_OUT   = 3'd6
    } op_e;

    typedef enum logic [1:0] {
        SZ_B = 2'd0,
        SZ_W = 2'd1,
        SZ_D = 2'd2
    } size_e;

    typedef enum logic [2:0] {
        RK_MRD  = 3'd0,
        RK_MWR  = 3'd1,
        RK_IORD = 3'd2,
        RK_IOWR = 3'd3,
        RK_PCHK = 3'd4
    } rkind_e;

    typedef enum logic [2:0] {
        PH_SRD  = 3'd0,
        PH_DRD  = 3'd1,
        PH_DWR  = 3'd2,
        PH_CHK  = 3'd3,
        PH_IORD = 3'd4,
        PH_IOWR = 3'd5,
        PH_END  = 3'd6
    } phase_e;

    typedef enum logic [2:0] {
        FC_NONE   = 3'd0,
        FC_SRCSEG = 3'd1,
        FC_DSTSEG = 3'd2,
        FC_ACCESS = 3'd3,
        FC_IOPERM = 3'd4
    } fcode_e;

    typedef struct packed {
        logic o;
        logic s;
        logic z;
        logic a;
        logic p;
        logic c;
    } flags_t;

    function automatic logic [2:0] elem_bytes(input logic [1:0] sz);
        case (sz)
            SZ_B:    return 3'd1;
            SZ_W:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [XW-1:0] width_mask(input logic [1:0] sz);
        case (sz)
            SZ_B:    return 32'h0000_00FF;
            SZ_W:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic top_bit(input logic [XW-1:0] v, input logic [1:0] sz);
        case (sz)
            SZ_B:    return v[7];
            SZ_W:    return v[15];
            default: return v[31];
        endcase
    endfunction

    function automatic logic reads_src(input op_e op);
        return (op == OP_MOVE) || (op == OP_CMP) || (op == OP_LOAD) || (op == OP_OUT);
    endfunction

    function automatic logic writes_dst(input op_e op);
        return (op == OP_MOVE) || (op == OP_STORE) || (op == OP_IN);
    endfunction

    function automatic logic reads_dst(input op_e op);
        return (op == OP_CMP) || (op == OP_SCAN);
    endfunction

    function automatic logic steps_dst(input op_e op);
        return (op == OP_MOVE) || (op == OP_CMP) || (op == OP_STORE) ||
               (op == OP_SCAN) || (op == OP_IN);
    endfunction

    function automatic logic [4:0] op_cost(input op_e op, input logic c486);
        case (op)
            OP_MOVE:  return 5'd7;
            OP_CMP:   return c486 ? 5'd8 : 5'd10;
            OP_STORE: return 5'd4;
            OP_LOAD:  return 5'd5;
            OP_SCAN:  return 5'd7;
            OP_IN:    return 5'd15;
            default:  return 5'd14;
        endcase
    endfunction

    function automatic phase_e first_phase(input op_e op);
        case (op)
            OP_STORE: return PH_DWR;
            OP_SCAN:  return PH_DRD;
            OP_IN:    return PH_CHK;
            default:  return PH_SRD;
        endcase
    endfunction

    function automatic phase_e next_phase(input op_e op, input phase_e ph);
        case (op)
            OP_MOVE: return (ph == PH_SRD) ? PH_DWR : PH_END;
            OP_CMP:  return (ph == PH_SRD) ? PH_DRD : PH_END;
            OP_IN: begin
                case (ph)
                    PH_CHK:  return PH_IORD;
                    PH_IORD: return PH_DWR;
                    default: return PH_END;
                endcase
            end
            OP_OUT: begin
                case (ph)
                    PH_SRD:  return PH_CHK;
                    PH_CHK:  return PH_IOWR;
                    default: return PH_END;
                endcase
            end
            default: return PH_END;
        endcase
    endfunction

    function automatic logic [XW-1:0] merge_acc(input logic [XW-1:0] acc,
                                                input logic [XW-1:0] v,
                                                input logic [1:0] sz);
        case (sz)
            SZ_B:    return {acc[31:8], v[7:0]};
            SZ_W:    return {acc[31:16], v[15:0]};
            default: return v;
        endcase
    endfunction

endpackage

// File: rtl/strop_idx_step.sv
module strop_idx_step
    import strop_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] idx,
    input  logic [1:0]   size,
    input  logic         dir,
    input  logic         wide,
    output logic [W-1:0] idx_nx
);
    localparam int NW = NARROW;

    logic [W-1:0]  delta;
    logic [W-1:0]  full_nx;
    logic [NW-1:0] low_nx;

    always_comb begin
        delta   = W'(elem_bytes(size));
        full_nx = dir ? (idx - delta) : (idx + delta);
        low_nx  = dir ? (idx[NW-1:0] - delta[NW-1:0]) : (idx[NW-1:0] + delta[NW-1:0]);
        idx_nx  = wide ? full_nx : {idx[W-1:NW], low_nx};
    end
endmodule

// File: rtl/strop_sub_flags.sv
module strop_sub_flags
    import strop_pkg::*;
(
    input  logic [XW-1:0] a,
    input  logic [XW-1:0] b,
    input  logic [1:0]    size,
    output flags_t        fl
);
    logic [XW-1:0] am, bm, res;
    logic          sa, sb, sr;

    always_comb begin
        am   = a & width_mask(size);
        bm   = b & width_mask(size);
        res  = (am - bm) & width_mask(size);
        sa   = top_bit(am, size);
        sb   = top_bit(bm, size);
        sr   = top_bit(res, size);
        fl.c = (am < bm);
        fl.z = (res == '0);
        fl.s = sr;
        fl.o = (sa != sb) && (sr != sa);
        fl.a = (am[3:0] < bm[3:0]);
        fl.p = ~^res[7:0];
    end
endmodule

// File: rtl/strop_seq.sv
module strop_seq
    import strop_pkg::*;
#(
    parameter int IDX_W  = 32,
    parameter int PORT_W = 16,
    parameter int CYC_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [2:0]        op_in,
    input  logic [1:0]        size_in,
    input  logic              addr32_in,
    input  logic              dir_in,
    input  logic              cmp486_in,
    input  logic [31:0]       acc_in,
    input  logic [IDX_W-1:0]  src_idx_in,
    input  logic [IDX_W-1:0]  dst_idx_in,
    input  logic [PORT_W-1:0] port_in,
    input  logic [31:0]       src_base_in,
    input  logic [31:0]       dst_base_in,
    input  logic              src_rd_ok,
    input  logic              dst_rd_ok,
    input  logic              dst_wr_ok,
    output logic              req_valid,
    output logic [2:0]        req_kind,
    output logic [31:0]       req_addr,
    output logic [1:0]        req_size,
    output logic [31:0]       req_wdata,
    input  logic              rsp_ready,
    input  logic              rsp_fault,
    input  logic [31:0]       rsp_rdata,
    output logic              busy,
    output logic              done,
    output logic              abort,
    output logic [2:0]        fault_code,
    output logic [IDX_W-1:0]  src_idx_out,
    output logic [IDX_W-1:0]  dst_idx_out,
    output logic [31:0]       acc_out,
    output logic [5:0]        flags_out,
    output logic [CYC_W-1:0]  cycles_out
);
    typedef struct packed {
        op_e               op;
        logic [1:0]        sz;
        logic              a32;
        logic              dir;
        logic              c486;
        logic [XW-1:0]     acc;
        logic [IDX_W-1:0]  si;
        logic [IDX_W-1:0]  di;
        logic [PORT_W-1:0] port;
        logic [XW-1:0]     sb;
        logic [XW-1:0]     db;
    } ctx_t;

    ctx_t          ctx;
    logic          run;
    phase_e        ph;
    logic [1:0]    chk_i;
    logic [XW-1:0] hold;
    logic          src_adv;

    logic [IDX_W-1:0] si_nx, di_nx, si_eff, di_eff;
    logic [XW-1:0]    src_addr, dst_addr, mask, rd_m, fa;
    logic [2:0]       nb;
    logic             chk_last, sf_src, sf_dst;
    phase_e           ph_nx;
    rkind_e           kind;
    flags_t           fl;
    op_e              op_req;

    strop_idx_step #(.W(IDX_W)) u_src_step (
        .idx(ctx.si), .size(ctx.sz), .dir(ctx.dir), .wide(ctx.a32), .idx_nx(si_nx)
    );
    strop_idx_step #(.W(IDX_W)) u_dst_step (
        .idx(ctx.di), .size(ctx.sz), .dir(ctx.dir), .wide(ctx.a32), .idx_nx(di_nx)
    );

    assign fa = (ctx.op == OP_SCAN) ? ctx.acc : hold;

    strop_sub_flags u_flags (
        .a(fa), .b(rsp_rdata), .size(ctx.sz), .fl(fl)
    );

    always_comb begin
        op_req   = op_e'(op_in);
        sf_src   = reads_src(op_req) && !src_rd_ok;
        sf_dst   = (writes_dst(op_req) && !dst_wr_ok) || (reads_dst(op_req) && !dst_rd_ok);
        nb       = elem_bytes(ctx.sz);
        mask     = width_mask(ctx.sz);
        rd_m     = rsp_rdata & mask;
        si_eff   = ctx.a32 ? ctx.si : {{(IDX_W-NARROW){1'b0}}, ctx.si[NARROW-1:0]};
        di_eff   = ctx.a32 ? ctx.di : {{(IDX_W-NARROW){1'b0}}, ctx.di[NARROW-1:0]};
        src_addr = ctx.sb + XW'(si_eff);
        dst_addr = ctx.db + XW'(di_eff);
        chk_last = ({1'b0, chk_i} == (nb - 3'd1));
        ph_nx    = (ph == PH_CHK && !chk_last) ? PH_CHK : next_phase(ctx.op, ph);
    end

    always_comb begin
        kind      = RK_MRD;
        req_addr  = '0;
        req_wdata = '0;
        case (ph)
            PH_SRD: begin
                kind     = RK_MRD;
                req_addr = src_addr;
            end
            PH_DRD: begin
                kind     = RK_MRD;
                req_addr = dst_addr;
            end
            PH_DWR: begin
                kind      = RK_MWR;
                req_addr  = dst_addr;
                req_wdata = (ctx.op == OP_STORE) ? (ctx.acc & mask) : hold;
            end
            PH_CHK: begin
                kind     = RK_PCHK;
                req_addr = XW'(ctx.port) + XW'(chk_i);
            end
            PH_IORD: begin
                kind     = RK_IORD;
                req_addr = XW'(ctx.port);
            end
            PH_IOWR: begin
                kind      = RK_IOWR;
                req_addr  = XW'(ctx.port);
                req_wdata = hold;
            end
            default: ;
        endcase
        req_valid = run;
        req_kind  = kind;
        req_size  = ctx.sz;
        busy      = run;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx         <= '0;
            run         <= 1'b0;
            ph          <= PH_END;
            chk_i       <= '0;
            hold        <= '0;
            src_adv     <= 1'b0;
            done        <= 1'b0;
            abort       <= 1'b0;
            fault_code  <= FC_NONE;
            src_idx_out <= '0;
            dst_idx_out <= '0;
            acc_out     <= '0;
            flags_out   <= '0;
            cycles_out  <= '0;
        end else begin
            done  <= 1'b0;
            abort <= 1'b0;
            if (!run) begin
                if (start) begin
                    ctx.op   <= op_req;
                    ctx.sz   <= size_in;
                    ctx.a32  <= addr32_in;
                    ctx.dir  <= dir_in;
                    ctx.c486 <= cmp486_in;
                    ctx.acc  <= acc_in;
                    ctx.si   <= src_idx_in;
                    ctx.di   <= dst_idx_in;
                    ctx.port <= port_in;
                    ctx.sb   <= src_base_in;
                    ctx.db   <= dst_base_in;
                    chk_i    <= '0;
                    hold     <= '0;
                    src_adv  <= 1'b0;
                    if (sf_src || sf_dst) begin
                        abort       <= 1'b1;
                        fault_code  <= sf_src ? FC_SRCSEG : FC_DSTSEG;
                        src_idx_out <= src_idx_in;
                        dst_idx_out <= dst_idx_in;
                        acc_out     <= acc_in;
                        cycles_out  <= '0;
                    end else begin
                        run <= 1'b1;
                        ph  <= first_phase(op_req);
                    end
                end
            end else if (rsp_fault) begin
                run         <= 1'b0;
                abort       <= 1'b1;
                fault_code  <= (ph == PH_CHK) ? FC_IOPERM : FC_ACCESS;
                src_idx_out <= src_adv ? si_nx : ctx.si;
                dst_idx_out <= ctx.di;
                acc_out     <= ctx.acc;
                cycles_out  <= '0;
            end else if (rsp_ready) begin
                if (ph == PH_SRD || ph == PH_IORD)
                    hold <= rd_m;
                if (ph == PH_CHK)
                    chk_i <= chk_last ? 2'd0 : chk_i + 2'd1;
                if (ph == PH_CHK && chk_last && ctx.op == OP_OUT)
                    src_adv <= 1'b1;
                ph <= ph_nx;
                if (ph_nx == PH_END) begin
                    run         <= 1'b0;
                    done        <= 1'b1;
                    fault_code  <= FC_NONE;
                    src_idx_out <= reads_src(ctx.op) ? si_nx : ctx.si;
                    dst_idx_out <= steps_dst(ctx.op) ? di_nx : ctx.di;
                    acc_out     <= (ctx.op == OP_LOAD) ? merge_acc(ctx.acc, rd_m, ctx.sz) : ctx.acc;
                    if (ctx.op == OP_CMP || ctx.op == OP_SCAN)
                        flags_out <= fl;
                    cycles_out  <= CYC_W'(op_cost(ctx.op, ctx.c486));
                end
            end
        end
    end

    // R10: completion and fault pulses are exclusive
    p_excl_r10: assert property (@(posedge clk) disable iff (rst) !(done && abort));

    // R10: a refused request is reported one cycle later
    p_fault_abort_r10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && rsp_fault) |=> (abort && !busy));

    // R11: completion leaves the block idle
    p_done_idle_r11: assert property (@(posedge clk) disable iff (rst) done |-> !busy);

    // R11: a request only exists during a pass
    p_req_busy_r11: assert property (@(posedge clk) disable iff (rst) req_valid |-> busy);

    // R11: an unanswered request is held unchanged
    p_req_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !rsp_ready && !rsp_fault) |=>
        (req_valid && $stable(req_addr) && $stable(req_kind) && $stable(req_wdata)));

    // R2: narrow addressing keeps the upper index bits
    p_hi_keep_r2: assert property (@(posedge clk) disable iff (rst)
        (done && !ctx.a32) |->
        (src_idx_out[IDX_W-1:NARROW] == ctx.si[IDX_W-1:NARROW] &&
         dst_idx_out[IDX_W-1:NARROW] == ctx.di[IDX_W-1:NARROW]));

    // R6: permission probes stay inside the covered port bytes
    p_chk_range_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == RK_PCHK) |-> ((req_addr - XW'(ctx.port)) < XW'(nb)));

    // R8: compare cost follows the mode bit
    p_cmp_cost_r8: assert property (@(posedge clk) disable iff (rst)
        (done && ctx.op == OP_CMP) |-> (cycles_out == (ctx.c486 ? CYC_W'(8) : CYC_W'(10))));

    // R9: a segment refusal never reaches the request channel
    p_seg_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (abort && (fault_code == FC_SRCSEG || fault_code == FC_DSTSEG)) |-> !req_valid);
endmodule

// File: tb/strop_seq_tb.sv
module strop_seq_tb;
    import strop_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  op_in = '0;
    logic [1:0]  size_in = '0;
    logic        addr32_in = 1'b0, dir_in = 1'b0, cmp486_in = 1'b0;
    logic [31:0] acc_in = '0, src_idx_in = '0, dst_idx_in = '0;
    logic [15:0] port_in = '0;
    logic [31:0] src_base_in = '0, dst_base_in = '0;
    logic        src_rd_ok = 1'b1, dst_rd_ok = 1'b1, dst_wr_ok = 1'b1;
    logic        req_valid;
    logic [2:0]  req_kind;
    logic [31:0] req_addr, req_wdata;
    logic [1:0]  req_size;
    logic        rsp_ready = 1'b0, rsp_fault = 1'b0;
    logic [31:0] rsp_rdata = '0;
    logic        busy, done, abort;
    logic [2:0]  fault_code;
    logic [31:0] src_idx_out, dst_idx_out, acc_out;
    logic [5:0]  flags_out;
    logic [4:0]  cycles_out;

    int          n_chk = 0;
    int          n_fail = 0;
    logic [5:0]  exp_flags = '0;

    always #2.5 clk = ~clk;

    strop_seq u_dut (
        .clk(clk), .rst(rst), .start(start), .op_in(op_in), .size_in(size_in),
        .addr32_in(addr32_in), .dir_in(dir_in), .cmp486_in(cmp486_in), .acc_in(acc_in),
        .src_idx_in(src_idx_in), .dst_idx_in(dst_idx_in), .port_in(port_in),
        .src_base_in(src_base_in), .dst_base_in(dst_base_in),
        .src_rd_ok(src_rd_ok), .dst_rd_ok(dst_rd_ok), .dst_wr_ok(dst_wr_ok),
        .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr), .req_size(req_size),
        .req_wdata(req_wdata), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault), .rsp_rdata(rsp_rdata),
        .busy(busy), .done(done), .abort(abort), .fault_code(fault_code),
        .src_idx_out(src_idx_out), .dst_idx_out(dst_idx_out), .acc_out(acc_out),
        .flags_out(flags_out), .cycles_out(cycles_out)
    );

    function automatic logic [31:0] mdata(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h00C3_A55A;
    endfunction

    function automatic logic [31:0] iodata(input logic [31:0] a);
        return (a * 32'h85EB_CA6B) ^ 32'h1234_F00D;
    endfunction

    function automatic logic [31:0] msk(input int sz);
        return (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
    endfunction

    function automatic logic [31:0] nidx(input logic [31:0] v, input int n, input bit a32, input bit dn);
        logic [15:0] lo;
        if (a32) return dn ? v - n : v + n;
        lo = dn ? v[15:0] - 16'(n) : v[15:0] + 16'(n);
        return {v[31:16], lo};
    endfunction

    function automatic logic [5:0] ref_flags(input logic [31:0] a, input logic [31:0] b, input int sz);
        longint ua, ub, r;
        int     hb;
        bit     c, z, s, o, ac, p, sa, sbt;
        ua = a & msk(sz);
        ub = b & msk(sz);
        r  = (ua - ub) & longint'(msk(sz));
        hb = (sz == 0) ? 7 : (sz == 1) ? 15 : 31;
        c  = ua < ub;
        z  = (r == 0);
        s  = r[hb];
        sa = ua[hb];
        sbt = ub[hb];
        o  = (sa != sbt) && (s != sa);
        ac = (ua & 15) < (ub & 15);
        p  = 1'b1;
        for (int i = 0; i < 8; i++) p = p ^ r[i];
        return {o, s, z, ac, p, c};
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic string optag(input int op);
        case (op)
            0: return "R3";
            1: return "R4";
            4: return "R4";
            2: return "R5";
            3: return "R5";
            5: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic run_iter(input int op, input int sz, input bit a32, input bit dn, input bit c486,
                            input logic [31:0] acc, input logic [31:0] si, input logic [31:0] di,
                            input logic [15:0] port, input logic [31:0] sb, input logic [31:0] db,
                            input int fault_at, input bit sok, input bit rok, input bit wok,
                            input int waits);
        int          kinds[8];
        logic [31:0] addrs[8];
        logic [31:0] wds[8];
        int          ne = 0;
        int          n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        logic [31:0] m = msk(sz);
        logic [31:0] sa = sb + (a32 ? si : {16'h0, si[15:0]});
        logic [31:0] da = db + (a32 ? di : {16'h0, di[15:0]});
        int          seg = 0;
        int          k = 0;
        int          stall = 0;
        int          wd = 0;
        bit          fdone;
        logic [31:0] e_si, e_di, e_acc;
        logic [4:0]  e_cyc;
        int          e_code;

        // expected access sequence
        if (op == 0) begin
            kinds[0] = 0; addrs[0] = sa; wds[0] = 0;
            kinds[1] = 1; addrs[1] = da; wds[1] = mdata(sa) & m; ne = 2;
        end else if (op == 1) begin
            kinds[0] = 0; addrs[0] = sa; wds[0] = 0;
            kinds[1] = 0; addrs[1] = da; wds[1] = 0; ne = 2;
        end else if (op == 2) begin
            kinds[0] = 1; addrs[0] = da; wds[0] = acc & m; ne = 1;
        end else if (op == 3) begin
            kinds[0] = 0; addrs[0] = sa; wds[0] = 0; ne = 1;
        end else if (op == 4) begin
            kinds[0] = 0; addrs[0] = da; wds[0] = 0; ne = 1;
        end else if (op == 5) begin
            for (int i = 0; i < n; i++) begin
                kinds[i] = 4; addrs[i] = {16'h0, port} + i; wds[i] = 0;
            end
            kinds[n] = 2; addrs[n] = {16'h0, port}; wds[n] = 0;
            kinds[n+1] = 1; addrs[n+1] = da; wds[n+1] = iodata({16'h0, port}) & m;
            ne = n + 2;
        end else begin
            kinds[0] = 0; addrs[0] = sa; wds[0] = 0;
            for (int i = 0; i < n; i++) begin
                kinds[i+1] = 4; addrs[i+1] = {16'h0, port} + i; wds[i+1] = 0;
            end
            kinds[n+1] = 3; addrs[n+1] = {16'h0, port}; wds[n+1] = mdata(sa) & m;
            ne = n + 2;
        end

        if ((op == 0 || op == 1 || op == 3 || op == 6) && !sok) seg = 1;
        else if (((op == 0 || op == 2 || op == 5) && !wok) || ((op == 1 || op == 4) && !rok)) seg = 2;

        @(negedge clk);
        op_in = 3'(op); size_in = 2'(sz); addr32_in = a32; dir_in = dn; cmp486_in = c486;
        acc_in = acc; src_idx_in = si; dst_idx_in = di; port_in = port;
        src_base_in = sb; dst_base_in = db;
        src_rd_ok = sok; dst_rd_ok = rok; dst_wr_ok = wok;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (seg == 0) check(busy == 1'b1, "R11", "busy after start", 32'(busy), 1);

        fdone = 0;
        forever begin
            rsp_ready = 1'b0; rsp_fault = 1'b0; rsp_rdata = 32'hDEAD_BEEF;
            if (done || abort) break;
            wd++;
            if (wd > 300) begin
                check(1'b0, "R11", "pass never ended", 0, 1);
                break;
            end
            if (req_valid) begin
                if (k >= ne) begin
                    check(1'b0, optag(op), "extra request", req_addr, 0);
                end else begin
                    check(req_kind == 3'(kinds[k]), optag(op), "request kind", 32'(req_kind), kinds[k]);
                    check(req_addr == addrs[k], (kinds[k] == 4) ? "R6" : (a32 ? "R1" : "R2"),
                          "request address", req_addr, addrs[k]);
                    check(req_size == 2'(sz), "R11", "request size", 32'(req_size), sz);
                    if (kinds[k] == 1 || kinds[k] == 3)
                        check(req_wdata == wds[k], optag(op), "write data", req_wdata, wds[k]);
                end
                if (stall < waits) begin
                    stall++;
                end else begin
                    stall = 0;
                    if (k == fault_at) begin
                        rsp_fault = 1'b1; fdone = 1;
                    end else begin
                        rsp_ready = 1'b1;
                        if (k < ne && kinds[k] == 0) rsp_rdata = mdata(addrs[k]);
                        else if (k < ne && kinds[k] == 2) rsp_rdata = iodata(addrs[k]);
                    end
                    k++;
                end
            end
            @(negedge clk);
        end

        // expected results
        e_si = si; e_di = di; e_acc = acc; e_cyc = 0; e_code = 0;
        if (seg != 0) begin
            e_code = seg;
            check(k == 0, "R9", "requests before segment abort", k, 0);
        end else if (fdone) begin
            e_code = (kinds[fault_at] == 4) ? 4 : 3;
            if (op == 6 && fault_at == ne - 1) e_si = nidx(si, n, a32, dn);
        end else begin
            check(k == ne, optag(op), "request count", k, ne);
            if (op == 0 || op == 1 || op == 3 || op == 6) e_si = nidx(si, n, a32, dn);
            if (op == 0 || op == 1 || op == 2 || op == 4 || op == 5) e_di = nidx(di, n, a32, dn);
            if (op == 3) begin
                if (sz == 0) e_acc = {acc[31:8], mdata(sa)[7:0]};
                else if (sz == 1) e_acc = {acc[31:16], mdata(sa)[15:0]};
                else e_acc = mdata(sa);
            end
            if (op == 1) exp_flags = ref_flags(mdata(sa), mdata(da), sz);
            if (op == 4) exp_flags = ref_flags(acc, mdata(da), sz);
            case (op)
                0: e_cyc = 7;
                1: e_cyc = c486 ? 8 : 10;
                2: e_cyc = 4;
                3: e_cyc = 5;
                4: e_cyc = 7;
                5: e_cyc = 15;
                default: e_cyc = 14;
            endcase
        end

        if (e_code == 0) begin
            check(done == 1'b1 && abort == 1'b0, "R11", "done pulse", {done, abort}, 2);
        end else begin
            check(abort == 1'b1 && done == 1'b0, "R10", "abort pulse", {done, abort}, 1);
        end
        check(busy == 1'b0, "R10", "busy at end", 32'(busy), 0);
        check(32'(fault_code) == e_code, (e_code == 1 || e_code == 2) ? "R9" : "R10",
              "fault code", 32'(fault_code), e_code);
        check(src_idx_out == e_si, (op == 6 && e_code == 3) ? "R7" : (a32 ? "R1" : "R2"),
              "source index", src_idx_out, e_si);
        check(dst_idx_out == e_di, a32 ? "R1" : "R2", "destination index", dst_idx_out, e_di);
        check(acc_out == e_acc, "R5", "accumulator", acc_out, e_acc);
        check(flags_out == exp_flags, "R4", "flags", 32'(flags_out), 32'(exp_flags));
        check(cycles_out == e_cyc, "R8", "cycle cost", 32'(cycles_out), 32'(e_cyc));
        @(negedge clk);
        check(done == 1'b0 && abort == 1'b0, "R11", "single-cycle pulse", {done, abort}, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R11 watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11: reset state
        check(busy == 0 && done == 0 && abort == 0 && req_valid == 0, "R11", "reset controls",
              {busy, done, abort, req_valid}, 0);
        check(src_idx_out == 0 && dst_idx_out == 0 && acc_out == 0, "R11", "reset results",
              src_idx_out | dst_idx_out | acc_out, 0);
        check(flags_out == 0 && cycles_out == 0 && fault_code == 0, "R11", "reset flags",
              {flags_out, cycles_out, fault_code}, 0);

        // R3 byte move, narrow, upward
        run_iter(0, 0, 0, 0, 0, 32'h1111_2222, 32'h5555_0010, 32'h6666_0020, 16'h0080,
                 32'h0001_0000, 32'h0002_0000, -1, 1, 1, 1, 0);
        // R1 doubleword move, wide, downward, wait states
        run_iter(0, 2, 1, 1, 0, 32'h0, 32'h0000_0100, 32'h0000_0200, 16'h0080,
                 32'h0010_0000, 32'h0020_0000, -1, 1, 1, 1, 2);
        // R4 word compare of equal operands: zero set
        run_iter(1, 1, 0, 0, 0, 32'h0, 32'h0000_0010, 32'h0000_0000, 16'h0,
                 32'h0000_1000, 32'h0000_1010, -1, 1, 1, 1, 0);
        check(flags_out[3] == 1'b1, "R4", "zero on equal compare", 32'(flags_out), 32'h8);
        // R8 compare cost in both modes
        run_iter(1, 0, 1, 0, 1, 32'h0, 32'h40, 32'h80, 16'h0, 32'h100, 32'h200, -1, 1, 1, 1, 0);
        // R4 scan with small accumulator
        run_iter(4, 2, 1, 0, 0, 32'h0000_0001, 32'h0, 32'h0000_0300, 16'h0,
                 32'h0, 32'h0000_4000, -1, 1, 1, 1, 1);
        // R2 store at the 16-bit upper wrap point
        run_iter(2, 1, 0, 0, 0, 32'hCAFE_BABE, 32'h0, 32'h7777_FFFF, 16'h0,
                 32'h0, 32'h0003_0000, -1, 1, 1, 1, 0);
        // R2 load downward across zero with upper bits set
        run_iter(3, 0, 0, 1, 0, 32'hAABB_CCDD, 32'h9999_0000, 32'h0, 16'h0,
                 32'h0004_0000, 32'h0, -1, 1, 1, 1, 0);
        // R6 doubleword port input
        run_iter(5, 2, 1, 0, 0, 32'h0, 32'h0, 32'h0000_0800, 16'h03F8,
                 32'h0, 32'h0005_0000, -1, 1, 1, 1, 0);
        // R7 word port output
        run_iter(6, 1, 0, 0, 0, 32'h0, 32'h0000_0044, 32'h0, 16'h0060,
                 32'h0006_0000, 32'h0, -1, 1, 1, 1, 1);
        // R7 fault on the port write leaves the source index stepped
        run_iter(6, 2, 1, 0, 0, 32'h0, 32'h0000_0044, 32'h0, 16'h0060,
                 32'h0006_0000, 32'h0, 5, 1, 1, 1, 0);
        // R6 / R10 permission refused on the third port byte
        run_iter(5, 2, 0, 1, 0, 32'h0, 32'h0, 32'h0000_0800, 16'h0070,
                 32'h0, 32'h0005_0000, 2, 1, 1, 1, 0);
        // R9 segment refusals for every kind
        for (int op = 0; op < 7; op++) begin
            run_iter(op, 0, 1, 0, 0, 32'h1234, 32'h10, 32'h20, 16'h10, 32'h100, 32'h200,
                     -1, 0, 1, 1, 0);
            run_iter(op, 1, 1, 0, 0, 32'h1234, 32'h10, 32'h20, 16'h10, 32'h100, 32'h200,
                     -1, 1, 0, 0, 0);
        end
        // R1 / R2 sweep of kinds, widths, modes and directions
        for (int op = 0; op < 7; op++)
            for (int sz = 0; sz < 3; sz++)
                for (int a = 0; a < 2; a++)
                    for (int d = 0; d < 2; d++) begin
                        run_iter(op, sz, a[0], d[0], d[0], mdata(32'(op * 7 + sz)),
                                 {16'h1230 + 16'(op), (d != 0 ? 16'h0001 : 16'hFFFE) + 16'(sz)},
                                 {16'hFED0 + 16'(sz), (d != 0 ? 16'h0002 : 16'hFFFD) + 16'(op)},
                                 16'h03F0 + 16'(op), 32'h0010_0000 + 32'(a * 16),
                                 32'h0800_0000, -1, 1, 1, 1, (op + sz) % 3);
                    end
        // R10 fault at every position of every kind
        for (int op = 0; op < 7; op++)
            for (int f = 0; f < 7; f++)
                run_iter(op, 2, 1, 0, 0, 32'h5A5A_A5A5, 32'h0000_2000 + 32'(f),
                         32'h0000_3000, 16'h0100, 32'h0, 32'h0100_0000, f, 1, 1, 1, f % 2);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule